// File: doc/BRIEF.md
# Parallel Fully-Connected Layer Engine

This block evaluates one fully-connected neural-network layer in signed fixed point. Features arrive from a show-ahead input FIFO, `P` features per word. Every output neuron has its own accumulator. In each cycle where the engine runs and the FIFO has data, every neuron accumulates `P` products, one per feature lane. The weights come from `P` matching rows of a constant weight table, which is computed from parameters. A pass over `N_IN` features therefore takes `N_IN/P` accepted words, and the engine holds `P*N_OUT` multipliers.

After the last word, each neuron adds its own bias. The bias is rescaled to the product scale. The sum then drops `M` low bits by an arithmetic right shift and goes through ReLU. All `N_OUT` results are written into a register buffer in a single cycle. A one-cycle `done` pulse follows, after which the buffer can be read by address through a combinational port.

A `start` pulse from idle clears every accumulator and begins a pass. With the default parameters (8 inputs, 4 outputs, 2 features per word, 8-bit values with 6 fraction bits, 4 dropped bits), the accumulator is 19 bits wide and each stored result is 15 bits wide.

Top module: `fc_layer_engine`

## Requirements
- R1: After reset, `busy`, `done` and `fifo_rd` are low, and every buffer address reads zero.
- R2: A `start` seen while idle begins a pass with all accumulators cleared, so a pass's results never depend on earlier passes.
- R3: Each accepted word carries feature `b*P+l` of beat `b` in bits `[l*K +: K]` (two's complement). A pass accepts exactly `N_IN/P` words.
- R4: `fifo_rd` is high only while a pass is running and `fifo_empty` is low. A cycle with an empty FIFO neither consumes nor accumulates anything.
- R5: Neuron `c` forms the exact dot product of the features with weights `w(j,c) = ((37j + 91c + 13) mod 29) - 14`, without overflow, even for all-extreme inputs.
- R6: Neuron `c` adds bias `b(c) = ((53c + 7) mod 41) - 20`, shifted left by `FRAC` bits to the product scale.
- R7: After the bias add, the sum is divided by 2^M by an arithmetic right shift, which discards the `M` low bits.
- R8: A shifted result that is zero or negative is stored as zero; a positive one is stored unchanged.
- R9: If the last word is read in cycle T, `done` is high in cycle T+2 only, and the buffer already holds the new results in that cycle.
- R10: A `start` while busy is ignored: the pass completes once, with unchanged results.
- R11: `rd_data` shows the buffer entry at `rd_addr` in the same cycle. Entries hold their values until the next pass writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass when idle |
| fifo_empty | input | 1 | Input FIFO has no word |
| fifo_data | input | K*P | Head word of the input FIFO, P signed features |
| fifo_rd | output | 1 | Consume the head word this cycle |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse: results stored |
| rd_addr | input | $clog2(N_OUT) | Output buffer read address |
| rd_data | output | $clog2(N_IN)+2K-M | Stored, non-negative result at rd_addr |

## Verification
The bench numbers the cycles after `start` and samples at the falling edge, so every output is observed in the cycle it belongs to. Each cycle it records where `fifo_rd` is high. It requires `done` exactly two cycles after the last read and for one cycle only. This holds for free-running input, for a FIFO that empties two cycles in three, and for a pass hit by a second `start`. It reads the buffer only after `done`, and again after idle cycles. The expected values come from the bench's own statement of the weight, bias, shift and ReLU rules.

// File: rtl/fc_layer_pkg.sv
package fc_layer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN,
    ST_DONE
  } fc_state_e;

  // Integer weight for input row j, output column c (already scaled and rounded).
  function automatic int fc_weight_val(input int j, input int c);
    return ((j * 37 + c * 91 + 13) % 29) - 14;
  endfunction

  // Integer bias for output column c, at feature scale.
  function automatic int fc_bias_val(input int c);
    return ((c * 53 + 7) % 41) - 20;
  endfunction

endpackage

// File: rtl/fc_weight_rom.sv
module fc_weight_rom
  import fc_layer_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 4,
  parameter int P     = 2,
  parameter int K     = 8,
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0]        beat,
  output logic signed [K-1:0]      w_row [P][N_OUT]
);
  localparam int ROW_W = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic signed [K-1:0] wtab [N_IN][N_OUT];

  for (genvar r = 0; r < N_IN; r++) begin : g_row
    for (genvar c = 0; c < N_OUT; c++) begin : g_col
      assign wtab[r][c] = K'(fc_weight_val(r, c));
    end
  end

  always_comb begin
    for (int l = 0; l < P; l++) begin
      logic [ROW_W-1:0] row;
      row = ROW_W'(beat * P + l);
      for (int c = 0; c < N_OUT; c++) begin
        w_row[l][c] = wtab[row][c];
      end
    end
  end

endmodule

// File: rtl/fc_neuron.sv
module fc_neuron #(
  parameter int P     = 2,
  parameter int K     = 8,
  parameter int ACC_W = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [K-1:0]     x [P],
  input  logic signed [K-1:0]     w [P],
  output logic signed [ACC_W-1:0] acc
);
  logic signed [ACC_W-1:0] beat_sum;
  logic signed [2*K-1:0]   prod;

  always_comb begin
    beat_sum = '0;
    prod     = '0;
    for (int l = 0; l < P; l++) begin
      prod     = x[l] * w[l];
      beat_sum = beat_sum + ACC_W'(prod);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= acc + beat_sum;
  end

endmodule

// File: rtl/fc_post.sv
module fc_post #(
  parameter int K     = 8,
  parameter int FRAC  = 6,
  parameter int M     = 4,
  parameter int ACC_W = 19,
  parameter int OUT_W = 15
) (
  input  logic signed [ACC_W-1:0] acc,
  input  logic signed [K-1:0]     bias,
  output logic [OUT_W-1:0]        q,
  output logic                    is_neg
);
  logic signed [ACC_W-1:0] with_bias;
  logic                    unused_low;

  always_comb begin
    with_bias = acc + (ACC_W'(bias) <<< FRAC);
    is_neg    = with_bias[ACC_W-1];
    q         = is_neg ? '0 : with_bias[ACC_W-1:M];
  end

  assign unused_low = ^with_bias[M-1:0];

endmodule

// File: rtl/fc_layer_engine.sv
module fc_layer_engine
  import fc_layer_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 4,
  parameter int P     = 2,
  parameter int K     = 8,
  parameter int FRAC  = 6,
  parameter int M     = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic                               fifo_empty,
  input  logic [K*P-1:0]                     fifo_data,
  output logic                               fifo_rd,
  output logic                               busy,
  output logic                               done,
  input  logic [$clog2(N_OUT)-1:0]           rd_addr,
  output logic [$clog2(N_IN)+2*K-M-1:0]      rd_data
);
  localparam int BEATS  = N_IN / P;
  localparam int BEAT_W = $clog2(BEATS + 1);
  localparam int ACC_W  = $clog2(N_IN) + 2 * K;
  localparam int OUT_W  = ACC_W - M;

  fc_state_e         state;
  logic [BEAT_W-1:0] beat;
  logic              start_ok;
  logic              last_beat;
  logic              buf_wr;

  logic signed [K-1:0]     feat    [P];
  logic signed [K-1:0]     w_row   [P][N_OUT];
  logic signed [ACC_W-1:0] acc_v   [N_OUT];
  logic [OUT_W-1:0]        q_v     [N_OUT];
  logic [N_OUT-1:0]        pre_neg;
  logic [OUT_W-1:0]        out_buf [N_OUT];

  assign start_ok  = start && (state == ST_IDLE);
  assign fifo_rd   = (state == ST_RUN) && !fifo_empty;
  assign last_beat = fifo_rd && (beat == BEAT_W'(BEATS - 1));
  assign buf_wr    = (state == ST_FIN);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_ok) begin
          state <= ST_RUN;
          beat  <= '0;
        end
        ST_RUN: if (fifo_rd) begin
          beat <= beat + 1'b1;
          if (last_beat) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar l = 0; l < P; l++) begin : g_lane
    assign feat[l] = fifo_data[l*K +: K];
  end

  fc_weight_rom #(
    .N_IN(N_IN), .N_OUT(N_OUT), .P(P), .K(K), .BEAT_W(BEAT_W)
  ) u_rom (
    .beat  (beat),
    .w_row (w_row)
  );

  for (genvar c = 0; c < N_OUT; c++) begin : g_neuron
    localparam logic signed [K-1:0] BIAS_C = K'(fc_bias_val(c));
    logic signed [K-1:0] w_col [P];

    for (genvar l = 0; l < P; l++) begin : g_w
      assign w_col[l] = w_row[l][c];
    end

    fc_neuron #(.P(P), .K(K), .ACC_W(ACC_W)) u_mac (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_ok),
      .en    (fifo_rd),
      .x     (feat),
      .w     (w_col),
      .acc   (acc_v[c])
    );

    fc_post #(
      .K(K), .FRAC(FRAC), .M(M), .ACC_W(ACC_W), .OUT_W(OUT_W)
    ) u_post (
      .acc    (acc_v[c]),
      .bias   (BIAS_C),
      .q      (q_v[c]),
      .is_neg (pre_neg[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_buf[c] <= '0;
      else if (buf_wr) out_buf[c] <= q_v[c];
    end
  end

  assign rd_data = out_buf[rd_addr];

endmodule

// File: rtl/fc_layer_checker.sv
module fc_layer_checker #(
  parameter int ACC_W  = 19,
  parameter int OUT_W  = 15,
  parameter int BEAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              start_ok,
  input logic              busy,
  input logic              fifo_empty,
  input logic              fifo_rd,
  input logic              done,
  input logic              buf_wr,
  input logic [BEAT_W-1:0] beat,
  input logic [ACC_W-1:0]  acc0,
  input logic              pre_neg0,
  input logic [OUT_W-1:0]  out0
);

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (busy && !fifo_empty)); // R4

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (acc0 == '0)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(buf_wr)); // R9

  AST_RELU_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && pre_neg0) |=> (out0 == '0)); // R8

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !fifo_rd && !done) |=> $stable(beat)); // R10

endmodule

bind fc_layer_engine fc_layer_checker #(
  .ACC_W(ACC_W), .OUT_W(OUT_W), .BEAT_W(BEAT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .start_ok   (start_ok),
  .busy       (busy),
  .fifo_empty (fifo_empty),
  .fifo_rd    (fifo_rd),
  .done       (done),
  .buf_wr     (buf_wr),
  .beat       (beat),
  .acc0       (acc_v[0]),
  .pre_neg0   (pre_neg[0]),
  .out0       (out_buf[0])
);

// File: tb/fc_layer_engine_tb.sv
module fc_layer_engine_tb;
  localparam int N_IN = 8, N_OUT = 4, P = 2, K = 8, FRAC = 6, M = 4;
  localparam int WORDS = N_IN / P;
  localparam int OUT_W = $clog2(N_IN) + 2 * K - M;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic stall = 1'b0;
  logic fifo_empty, fifo_rd, busy, done;
  logic [K*P-1:0] fifo_data;
  logic [$clog2(N_OUT)-1:0] rd_addr = '0;
  logic [OUT_W-1:0] rd_data;

  int checks = 0, fails = 0;
  logic [K*P-1:0] fq [64];
  int fcnt = 0, fidx = 0;

  always #5 clk = ~clk;

  assign fifo_empty = stall || (fidx >= fcnt);
  assign fifo_data  = fq[fidx % 64];
  always @(posedge clk) if (fifo_rd) fidx <= fidx + 1;

  fc_layer_engine #(.N_IN(N_IN), .N_OUT(N_OUT), .P(P), .K(K), .FRAC(FRAC), .M(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_rd(fifo_rd), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int tb_w(int j, int c);
    int s = 13 + 37 * j + 91 * c;
    return s - 29 * (s / 29) - 14;
  endfunction

  function automatic int tb_b(int c);
    int s = 7 + 53 * c;
    return s - 41 * (s / 41) - 20;
  endfunction

  function automatic int tb_expect(int f[N_IN], int c);
    longint s = 0;
    longint t;
    for (int j = 0; j < N_IN; j++) s += f[j] * tb_w(j, c);
    s += tb_b(c) * (1 << FRAC);
    t = s >>> M;
    return (t > 0) ? int'(t) : 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_buffer(string tag, int f[N_IN]);
    for (int c = 0; c < N_OUT; c++) begin
      @(negedge clk);
      rd_addr = c[$clog2(N_OUT)-1:0];
      #1;
      check(tag, int'(rd_data), tb_expect(f, c));
    end
  endtask

  // One pass: stall_mode empties the FIFO two cycles in three; poke sends a start mid-pass.
  task automatic run_pass(string tag, int f[N_IN], bit stall_mode, bit poke);
    int t = 0, reads = 0, t_last = -1, t_done = -1, dcount = 0, bad_rd = 0;
    for (int b = 0; b < WORDS; b++)
      fq[(fcnt + b) % 64] = {K'(f[2*b+1]), K'(f[2*b])};
    fcnt += WORDS;
    @(negedge clk);
    start = 1'b1;
    while (1) begin
      @(negedge clk);
      t++;
      start = poke && (t == 2);
      stall = stall_mode && (t % 3 != 0);
      #1;
      if (fifo_rd) begin reads++; t_last = t; if (stall) bad_rd++; end
      if (done) begin dcount++; if (t_done < 0) t_done = t; end
      if (t_done >= 0 && t > t_done + 3) break;
      if (t > 300) begin
        fails++;
        $display("FAIL %s watchdog: actual no done expected done", tag);
        break;
      end
    end
    stall = 1'b0;
    start = 1'b0;
    check({tag, " R3 words read"}, reads, WORDS);
    check({tag, " R4 read while empty"}, bad_rd, 0);
    check({tag, " R9 done delay"}, t_done - t_last, 2);
    check({tag, " R9 R10 done count"}, dcount, 1);
    check_buffer({tag, " R2 R5 R6 R7 R8 result"}, f);
  endtask

  task automatic test_reset();
    #1;
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 fifo_rd", int'(fifo_rd), 0);
    for (int c = 0; c < N_OUT; c++) begin
      rd_addr = c[$clog2(N_OUT)-1:0];
      #1;
      check("R1 buffer zero", int'(rd_data), 0);
    end
  endtask

  task automatic test_hold(int f[N_IN]);
    repeat (5) @(negedge clk);
    check_buffer("R11 hold", f);
  endtask

  initial begin
    int fa[N_IN] = '{10, -20, 30, -40, 50, -60, 70, -80};
    int fb[N_IN] = '{127, 127, 127, 127, 127, 127, 127, 127};
    int fc[N_IN] = '{-128, -128, -128, -128, -128, -128, -128, -128};
    int fd[N_IN] = '{1, 2, 3, 4, 5, 6, 7, 8};
    int fe[N_IN] = '{-5, 100, -100, 64, 0, 33, -77, 12};
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    run_pass("mixed", fa, 1'b0, 1'b0);
    run_pass("R5 max", fb, 1'b0, 1'b0);
    run_pass("R5 min", fc, 1'b0, 1'b0);
    test_hold(fc);
    run_pass("R4 stalled", fe, 1'b1, 1'b0);
    run_pass("R10 start busy", fd, 1'b0, 1'b1);
    run_pass("R10 start busy stalled", fa, 1'b1, 1'b1);
    test_hold(fa);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule